// File: doc/BRIEF.md
# Pipelined Reduction ALU

This unit takes one arithmetic operation per cycle from an upstream ready queue and folds its outcome into a running partial result. Each partial result belongs to a flow, and the unit keeps a small table of these partials, one entry per flow. Every operation carries an opcode, two 32-bit two's complement operands, a flow tag and a "first" flag. The opcode picks one of several things to do with the operands: a reduction operator (sum, xor, and, signed min, signed max), a multiply-accumulate, or a single-operand move or constant assignment.

The multiply is split across a chain of register stages, and each stage adds one 8-bit slice of the partial products. Because of this split a new operation can enter on every cycle. All opcodes take the same path, so every operation has the same fixed latency, and results come out in the order the operations went in. Each result appears on the output with its flow tag and opcode, together with the new partial value for that flow. The same value is written into the flow's table entry. A consumer counts completions per flow from the result strobe.

When an operation has the first flag set, it combines with the identity value of its operator instead of the stored partial. This lets a new reduction start without a separate clear.

Top module: `reduction_alu`

## Requirements
- R1: Synchronous active-low reset clears the result strobe and sets every flow's stored partial to zero. After reset, an operation without the first flag combines with zero.
- R2: An operation accepted on a clock edge produces its result strobe exactly 9 edges later, for every opcode. Results leave in the order of issue, and each accepted operation yields exactly one result.
- R3: Opcode 5 (multiply-accumulate) adds the low 32 bits of a times b to the flow's partial.
- R4: Opcode 0 (sum), opcode 1 (xor) and opcode 2 (and) combine operand a into the flow's partial with wrapping add, bitwise xor and bitwise and.
- R5: Opcode 3 (min) and opcode 4 (max) keep the smaller and the larger of operand a and the partial, compared as signed 32-bit values.
- R6: With the first flag set, the combine starts from the operator's identity instead of the stored partial. The identity is 0 for sum, xor and multiply-accumulate, all ones for and, 0x7FFFFFFF for min and 0x80000000 for max.
- R7: Opcode 6 (move) sets the partial to operand a, and opcode 7 (constant assign) sets it to operand b. Neither is affected by the other operand, the old partial or the first flag.
- R8: Operand b has no effect on opcodes 0 to 4.
- R9: Operations can be issued on every cycle. Back-to-back operations on the same flow each see the partial left by the one before.
- R10: Each result carries the flow tag and opcode of its operation, and the reported value becomes the flow's stored partial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 3 | Opcode (0 sum, 1 xor, 2 and, 3 min, 4 max, 5 mac, 6 move, 7 const) |
| in_first | input | 1 | Start from the operator's identity value |
| in_flow | input | 3 | Flow tag selecting the partial-result entry |
| in_a | input | 32 | Operand a |
| in_b | input | 32 | Operand b |
| res_valid | output | 1 | Result strobe, one per completed operation |
| res_flow | output | 3 | Flow tag of the result |
| res_op | output | 3 | Opcode of the result |
| res_value | output | 32 | New partial result of that flow |

## Verification
On every cycle, the assertions check four things. The number of operations in flight stays within the pipeline depth, and no result appears without an earlier issue. The multiply that the stages build slice by slice equals the full product of the operands carried along. The stored entry takes the reported value, and min, max and and results stay bounded by their operand. Only the directed scenarios can show the rest: the exact 9-cycle latency, the identity seeding, that move and constant assign ignore the other operand, and that back-to-back updates to one flow chain correctly. For these, the bench compares every result against its own flow model.

// File: rtl/rdu_pkg.sv
// Shared opcode encoding for the reduction ALU.
package rdu_pkg;
    typedef enum logic [2:0] {
        RDU_SUM = 3'd0,
        RDU_XOR = 3'd1,
        RDU_AND = 3'd2,
        RDU_MIN = 3'd3,
        RDU_MAX = 3'd4,
        RDU_MAC = 3'd5,
        RDU_MOV = 3'd6,
        RDU_CST = 3'd7
    } rdu_op_e;
endpackage

// File: rtl/rdu_mul_stage.sv
// One stage of the issue-to-combine pipeline.
// It registers the operation fields and adds one CW-bit slice of the
// product a*b (slice IDX of operand b) to the running accumulator.
// Stages whose slice lies beyond DW only delay the fields.
// Assumes CW divides the multiply into slices that the stage count covers.
module rdu_mul_stage #(
    parameter int DW  = 32,
    parameter int FW  = 3,
    parameter int CW  = 8,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_vld,
    input  logic [2:0]    i_op,
    input  logic          i_first,
    input  logic [FW-1:0] i_flow,
    input  logic [DW-1:0] i_a,
    input  logic [DW-1:0] i_b,
    input  logic [DW-1:0] i_acc,
    output logic          o_vld,
    output logic [2:0]    o_op,
    output logic          o_first,
    output logic [FW-1:0] o_flow,
    output logic [DW-1:0] o_a,
    output logic [DW-1:0] o_b,
    output logic [DW-1:0] o_acc
);
    localparam int SH = IDX * CW;
    localparam logic [DW-1:0] CMASK = (DW'(1) << CW) - DW'(1);

    logic [DW-1:0] pp;

    generate
        if (SH < DW) begin : g_slice
            logic [DW-1:0] chunk;
            // select this stage's slice of b and form its shifted partial product
            always_comb begin
                chunk = (i_b >> SH) & CMASK;
                pp    = (i_a * chunk) << SH;
            end
        end else begin : g_pass
            // no slice left: accumulator passes through unchanged
            always_comb pp = '0;
        end
    endgenerate

    // register the operation fields and the updated accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld   <= 1'b0;
            o_op    <= '0;
            o_first <= 1'b0;
            o_flow  <= '0;
            o_a     <= '0;
            o_b     <= '0;
            o_acc   <= '0;
        end else begin
            o_vld   <= i_vld;
            o_op    <= i_op;
            o_first <= i_first;
            o_flow  <= i_flow;
            o_a     <= i_a;
            o_b     <= i_b;
            o_acc   <= i_acc + pp;
        end
    end
endmodule

// File: rtl/rdu_combine.sv
// Combinational combine step: it picks the base (the identity or the stored
// partial) and applies the opcode. Move and constant assign bypass the base.
// Assumes two's complement data; min and max compare as signed values.
module rdu_combine #(
    parameter int DW = 32
) (
    input  logic [2:0]    i_op,
    input  logic          i_first,
    input  logic [DW-1:0] i_old,
    input  logic [DW-1:0] i_a,
    input  logic [DW-1:0] i_b,
    input  logic [DW-1:0] i_prod,
    output logic [DW-1:0] o_val
);
    import rdu_pkg::*;

    rdu_op_e       op;
    logic [DW-1:0] ident;
    logic [DW-1:0] base;

    // identity element of the operator selected by the opcode
    always_comb begin
        op = rdu_op_e'(i_op);
        unique case (op)
            RDU_AND: ident = '1;
            RDU_MIN: ident = {1'b0, {(DW-1){1'b1}}};
            RDU_MAX: ident = {1'b1, {(DW-1){1'b0}}};
            default: ident = '0;
        endcase
        base = i_first ? ident : i_old;
    end

    // apply the operator to the base and the operation's value
    always_comb begin
        unique case (op)
            RDU_SUM: o_val = base + i_a;
            RDU_XOR: o_val = base ^ i_a;
            RDU_AND: o_val = base & i_a;
            RDU_MIN: o_val = ($signed(i_a) < $signed(base)) ? i_a : base;
            RDU_MAX: o_val = ($signed(i_a) > $signed(base)) ? i_a : base;
            RDU_MAC: o_val = base + i_prod;
            RDU_MOV: o_val = i_a;
            RDU_CST: o_val = i_b;
            default: o_val = base;
        endcase
    end
endmodule

// File: rtl/rdu_flow_store.sv
// Final stage: it holds the per-flow partial results, combines the arriving
// operation with its flow's entry, writes the entry back and registers the
// tagged result. One read-modify-write per cycle, so consecutive operations
// on one flow chain without forwarding. Assumes FLOWS equals 2**FW.
module rdu_flow_store #(
    parameter int DW    = 32,
    parameter int FLOWS = 8,
    parameter int FW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_vld,
    input  logic [2:0]    i_op,
    input  logic          i_first,
    input  logic [FW-1:0] i_flow,
    input  logic [DW-1:0] i_a,
    input  logic [DW-1:0] i_b,
    input  logic [DW-1:0] i_prod,
    output logic          res_valid,
    output logic [FW-1:0] res_flow,
    output logic [2:0]    res_op,
    output logic [DW-1:0] res_value
);
    import rdu_pkg::*;

    logic [DW-1:0] part_q [FLOWS];
    logic [DW-1:0] cur;
    logic [DW-1:0] nval;

    // read the current partial of the arriving operation's flow
    always_comb cur = part_q[i_flow];

    rdu_combine #(.DW(DW)) u_comb (
        .i_op   (i_op),
        .i_first(i_first),
        .i_old  (cur),
        .i_a    (i_a),
        .i_b    (i_b),
        .i_prod (i_prod),
        .o_val  (nval)
    );

    // write back the new partial and register the tagged result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FLOWS; i++) part_q[i] <= '0;
            res_valid <= 1'b0;
            res_flow  <= '0;
            res_op    <= '0;
            res_value <= '0;
        end else begin
            res_valid <= i_vld;
            if (i_vld) begin
                part_q[i_flow] <= nval;
                res_flow       <= i_flow;
                res_op         <= i_op;
                res_value      <= nval;
            end
        end
    end

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        i_vld |=> part_q[$past(i_flow)] == res_value); // R10
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && i_op == RDU_MIN) |=> $signed(res_value) <= $signed($past(i_a))); // R5
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && i_op == RDU_MAX) |=> $signed(res_value) >= $signed($past(i_a))); // R5
    AST_AND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && i_op == RDU_AND) |=> (res_value & ~$past(i_a)) == '0); // R4
endmodule

// File: rtl/reduction_alu.sv
// Top of the reduction ALU. LAT-1 generated stages carry every operation and
// build the multiply slice by slice. The flow store then combines and
// registers the result, so the latency is LAT edges for all opcodes.
// Assumes LAT-1 stages cover DW/CW product slices.
module reduction_alu #(
    parameter int DW    = 32,
    parameter int FLOWS = 8,
    parameter int LAT   = 9,
    parameter int CW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               in_op,
    input  logic                     in_first,
    input  logic [$clog2(FLOWS)-1:0] in_flow,
    input  logic [DW-1:0]            in_a,
    input  logic [DW-1:0]            in_b,
    output logic                     res_valid,
    output logic [$clog2(FLOWS)-1:0] res_flow,
    output logic [2:0]               res_op,
    output logic [DW-1:0]            res_value
);
    import rdu_pkg::*;

    localparam int FW  = $clog2(FLOWS);
    localparam int NST = LAT - 1;
    localparam int OW  = $clog2(LAT + 1) + 1;

    logic [NST:0]         st_vld;
    logic [NST:0]         st_first;
    logic [NST:0][2:0]    st_op;
    logic [NST:0][FW-1:0] st_flow;
    logic [NST:0][DW-1:0] st_a;
    logic [NST:0][DW-1:0] st_b;
    logic [NST:0][DW-1:0] st_acc;

    // feed the issue port into the head of the stage chain
    always_comb begin
        st_vld[0]   = in_valid;
        st_op[0]    = in_op;
        st_first[0] = in_first;
        st_flow[0]  = in_flow;
        st_a[0]     = in_a;
        st_b[0]     = in_b;
        st_acc[0]   = '0;
    end

    generate
        for (genvar g = 0; g < NST; g++) begin : g_stage
            rdu_mul_stage #(.DW(DW), .FW(FW), .CW(CW), .IDX(g)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .i_vld  (st_vld[g]),
                .i_op   (st_op[g]),
                .i_first(st_first[g]),
                .i_flow (st_flow[g]),
                .i_a    (st_a[g]),
                .i_b    (st_b[g]),
                .i_acc  (st_acc[g]),
                .o_vld  (st_vld[g+1]),
                .o_op   (st_op[g+1]),
                .o_first(st_first[g+1]),
                .o_flow (st_flow[g+1]),
                .o_a    (st_a[g+1]),
                .o_b    (st_b[g+1]),
                .o_acc  (st_acc[g+1])
            );
        end
    endgenerate

    rdu_flow_store #(.DW(DW), .FLOWS(FLOWS), .FW(FW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_vld    (st_vld[NST]),
        .i_op     (st_op[NST]),
        .i_first  (st_first[NST]),
        .i_flow   (st_flow[NST]),
        .i_a      (st_a[NST]),
        .i_b      (st_b[NST]),
        .i_prod   (st_acc[NST]),
        .res_valid(res_valid),
        .res_flow (res_flow),
        .res_op   (res_op),
        .res_value(res_value)
    );

    logic [OW-1:0] inflight_q;

    // count operations between issue and result, for the checks below
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + OW'(in_valid) - OW'(res_valid);
    end

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= OW'(LAT)); // R2
    AST_RES_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> inflight_q != '0); // R2
    AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld[NST] && st_op[NST] == RDU_MAC) |-> st_acc[NST] == DW'(st_a[NST] * st_b[NST])); // R3
endmodule

// File: tb/tb_reduction_alu.sv
module tb_reduction_alu;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 9;
    localparam int WDOG       = 20000;
    localparam logic [2:0] O_SUM = 3'd0, O_XOR = 3'd1, O_AND = 3'd2, O_MIN = 3'd3,
                           O_MAX = 3'd4, O_MAC = 3'd5, O_MOV = 3'd6, O_CST = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_first = 1'b0;
    logic [2:0]  in_flow = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        res_valid;
    logic [2:0]  res_flow;
    logic [2:0]  res_op;
    logic [31:0] res_value;

    reduction_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_first(in_first), .in_flow(in_flow), .in_a(in_a), .in_b(in_b),
        .res_valid(res_valid), .res_flow(res_flow), .res_op(res_op),
        .res_value(res_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] mdl [8];
    logic [31:0] e_val  [256];
    logic [2:0]  e_flow [256];
    logic [2:0]  e_op   [256];
    int          e_cyc  [256];
    string       e_req  [256];
    int wr = 0;
    int rd = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [2:0] op, input bit first,
                                          input logic [31:0] old, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] s;
        s = old;
        if (first) begin
            if (op == O_AND)      s = 32'hFFFF_FFFF;
            else if (op == O_MIN) s = 32'h7FFF_FFFF;
            else if (op == O_MAX) s = 32'h8000_0000;
            else                  s = 32'h0;
        end
        case (op)
            O_SUM: return s + a;
            O_XOR: return s ^ a;
            O_AND: return s & a;
            O_MIN: return ($signed(a) < $signed(s)) ? a : s;
            O_MAX: return ($signed(a) > $signed(s)) ? a : s;
            O_MAC: return s + a * b;
            O_MOV: return a;
            default: return b;
        endcase
    endfunction

    // watchdog and cycle counter
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // result monitor: order, value, tags and latency of every result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (rd == wr) begin
                check(1'b0, "R2", "unexpected result", res_value, 32'h0);
            end else begin
                check(res_value == e_val[rd], e_req[rd], "value", res_value, e_val[rd]);
                check(res_flow == e_flow[rd] && res_op == e_op[rd], "R10", "flow/op tag",
                      {26'h0, res_flow, res_op}, {26'h0, e_flow[rd], e_op[rd]});
                check(cyc - e_cyc[rd] == LATENCY, "R2", "latency",
                      32'(cyc - e_cyc[rd]), 32'(LATENCY));
                rd++;
            end
        end
    end

    task automatic issue(input logic [2:0] op, input bit first, input logic [2:0] flow,
                         input logic [31:0] a, input logic [31:0] b, input string req);
        logic [31:0] v;
        v = model(op, first, mdl[flow], a, b);
        mdl[flow] = v;
        e_val[wr] = v; e_flow[wr] = flow; e_op[wr] = op; e_cyc[wr] = cyc; e_req[wr] = req;
        wr++;
        in_valid = 1'b1; in_op = op; in_first = first; in_flow = flow; in_a = a; in_b = b;
        @(negedge clk);
    endtask

    task automatic drain(input string tag);
        in_valid = 1'b0;
        in_b = 32'h5A5A_5A5A;
        repeat (LATENCY + 3) @(negedge clk);
        check(rd == wr, "R2", {"all results returned ", tag}, 32'(rd), 32'(wr));
    endtask

    task automatic t_reset();
        check(res_valid == 1'b0, "R1", "strobe low after reset", {31'h0, res_valid}, 32'h0);
        issue(O_SUM, 0, 3'd5, 32'd77, 32'd0, "R1");
        drain("reset");
    endtask

    task automatic t_sum();
        issue(O_SUM, 1, 3'd0, 32'd5, 32'd0, "R4");
        issue(O_SUM, 0, 3'd0, 32'hFFFF_FFFD, 32'd1234, "R8");
        issue(O_SUM, 0, 3'd0, 32'h7FFF_FFFF, 32'hFFFF_0000, "R4");
        drain("sum");
    endtask

    task automatic t_logic();
        issue(O_XOR, 1, 3'd1, 32'h0000_F0F0, 32'h1111_1111, "R6");
        issue(O_XOR, 0, 3'd1, 32'h0000_0FF0, 32'h0, "R4");
        issue(O_AND, 1, 3'd2, 32'hFFFF_00FF, 32'h0, "R6");
        issue(O_AND, 0, 3'd2, 32'h0F0F_0F0F, 32'hFFFF_FFFF, "R8");
        drain("logic");
    endtask

    task automatic t_minmax();
        issue(O_MIN, 1, 3'd3, 32'h7FFF_FFFF, 32'h0, "R6");
        issue(O_MIN, 0, 3'd3, 32'hFFFF_FFFB, 32'h8000_0000, "R5");
        issue(O_MIN, 0, 3'd3, 32'd10, 32'h0, "R5");
        issue(O_MAX, 1, 3'd4, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
        issue(O_MAX, 0, 3'd4, 32'hFFFF_FFF9, 32'h0, "R5");
        issue(O_MAX, 0, 3'd4, 32'd3, 32'h0, "R5");
        drain("minmax");
    endtask

    task automatic t_mac();
        issue(O_MAC, 1, 3'd6, 32'd1000, 32'hFFFF_F448, "R3");
        issue(O_MAC, 0, 3'd6, 32'h1234_5678, 32'h9ABC_DEF0, "R3");
        issue(O_MAC, 0, 3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        drain("mac");
    endtask

    task automatic t_move();
        issue(O_MOV, 0, 3'd7, 32'h0000_DEAD, 32'd5, "R7");
        issue(O_CST, 1, 3'd7, 32'd9, 32'h0000_BEEF, "R7");
        issue(O_SUM, 0, 3'd7, 32'd1, 32'h0, "R7");
        drain("move");
    endtask

    task automatic t_interleave();
        for (int i = 0; i < 6; i++) begin
            issue(O_SUM, 0, 3'(i % 2), 32'(i * 3 + 1), 32'h0, "R9");
        end
        for (int i = 0; i < 5; i++) begin
            issue(O_MAC, 0, 3'd6, 32'(i + 2), 32'(i * 7 - 3), "R9");
        end
        issue(O_MAX, 0, 3'd4, 32'd100, 32'h0, "R9");
        issue(O_MAX, 0, 3'd4, 32'd50, 32'h0, "R9");
        drain("interleave");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sum();
        t_logic();
        t_minmax();
        t_mac();
        t_move();
        t_interleave();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule